// File: doc/BRIEF.md
# Boolean-Masked Register Datapath

This block is the register-and-execute core of a processor datapath hardened against power and electromagnetic analysis. No architectural value is ever stored in the clear. Each register entry holds two halves: a share, kept in a data register file, and the mask that belongs to it, kept in a second register file of the same depth. The plain value is always the share XOR the mask.

Raw data enters only through the load operation. A load masks the incoming word with a fresh value from an on-chip LFSR. Register-to-register XOR and re-mask operations inject a new random value into both halves of the result, so the result does not inherit an operand's mask unchanged. A move copies both halves as they are. A store presents both halves of a register on a transfer port. A separate unmask port returns the recombined plain value at the point where a caller needs it.

Results pass through one execute register on their way to the register files. The mask moves in step with its share through that stage. The files are written one cycle after issue. Bypass paths make each result visible to the next operation and to the unmask port. A start pulse loads a new LFSR seed at the beginning of each run.

Top module: `masked_regdp`

## Requirements
- R1: One cycle after `um_addr` is sampled, `um_share` and `um_mask` hold the two halves of that register, and `um_plain` holds their XOR, which equals the plain reference value. The state seen includes every operation issued on earlier edges and excludes the operation issued on the same edge.
- R2: LOAD (`op_code`=1) writes share = `ld_data` XOR r and mask = r into register `rd`, where r is the current LFSR state.
- R3: XOR (`op_code`=2) writes share = sA^sB^r and mask = mA^mB^r into `rd`, where A is register `ra` and B is register `rb`. The plain result is plainA XOR plainB.
- R4: MOVE (`op_code`=3) copies the share and mask of `ra` into `rd` unchanged. It consumes no random value.
- R5: REMASK (`op_code`=4) writes share = sA^r and mask = mA^r into `rd`. The plain value is unchanged.
- R6: STORE (`op_code`=5) sets `st_valid` high one cycle later, with `st_share`/`st_mask` equal to the halves of `ra`. When no store was issued on the previous edge, `st_valid` is 0 and both outputs are 0. Codes 0, 6 and 7, and any cycle with `op_valid` low, have no effect.
- R7: The LFSR is 32 bits wide and shifts right in Galois form with feedback mask 32'h80200003 (x^32+x^22+x^2+x+1). It steps once on each edge where LOAD, XOR or REMASK is issued, holds otherwise, and is never zero.
- R8: When `start` is high, the LFSR loads `seed_in` on that edge, or 32'h1D872B41 if `seed_in` is zero. This takes priority over stepping. An operation issued on the same edge uses the old state.
- R9: Register 0 reads as zero share and zero mask. Writes to it are discarded.
- R10: An operation issued on the edge right after a write to its source register sees the new value through the bypass path.
- R11: After reset, all entries are zero, the LFSR holds 32'h1D872B41, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin-run pulse, reloads the LFSR seed |
| seed_in | input | 32 | Seed loaded on `start` |
| op_valid | input | 1 | Operation issue strobe |
| op_code | input | 3 | 1 LOAD, 2 XOR, 3 MOVE, 4 REMASK, 5 STORE, others no-op |
| rd | input | 4 | Destination register |
| ra | input | 4 | First source register |
| rb | input | 4 | Second source register |
| ld_data | input | 32 | Raw load word |
| um_addr | input | 4 | Register to unmask |
| um_plain | output | 32 | Recombined plain value |
| um_share | output | 32 | Share half of the register read |
| um_mask | output | 32 | Mask half of the register read |
| st_valid | output | 1 | Store transfer valid |
| st_share | output | 32 | Stored share |
| st_mask | output | 32 | Stored mask |

## Verification
An unmask read can fall on the same edge as a write to the same register, or on the edge after that write while the result is still in the execute stage. The bench forces both cases on purpose. It loads a register and unmasks it on the same edge, then reads it again on the next edge. It also chains dependent XORs back to back. A behavioural model applies each operation only after computing that edge's expected outputs, so the old value is expected on the same edge and the new value on the following edge. The bench also pairs a start pulse with a mask-consuming load, to confirm that the load uses the old random value and that the reseed still takes effect.

// File: rtl/mdp_pkg.sv
`timescale 1ns/1ps
package mdp_pkg;
  localparam int DW = 32;
  localparam logic [DW-1:0] LFSR_TAPS    = 32'h8020_0003;
  localparam logic [DW-1:0] LFSR_DEFAULT = 32'h1D87_2B41;

  localparam logic [2:0] OPC_NOP    = 3'd0;
  localparam logic [2:0] OPC_LOAD   = 3'd1;
  localparam logic [2:0] OPC_XOR    = 3'd2;
  localparam logic [2:0] OPC_MOVE   = 3'd3;
  localparam logic [2:0] OPC_REMASK = 3'd4;
  localparam logic [2:0] OPC_STORE  = 3'd5;

  typedef struct packed {
    logic [DW-1:0] share;
    logic [DW-1:0] mask;
  } pair_t;

  function automatic logic [DW-1:0] lfsr_step(input logic [DW-1:0] s,
                                              input logic [DW-1:0] taps);
    return s[0] ? ((s >> 1) ^ taps) : (s >> 1);
  endfunction

  function automatic logic [DW-1:0] reveal(input pair_t p);
    return p.share ^ p.mask;
  endfunction

  function automatic pair_t refresh(input pair_t p, input logic [DW-1:0] r);
    pair_t q;
    q.share = p.share ^ r;
    q.mask  = p.mask ^ r;
    return q;
  endfunction

  function automatic pair_t combine(input pair_t a, input pair_t b,
                                    input logic [DW-1:0] r);
    pair_t q;
    q.share = a.share ^ b.share ^ r;
    q.mask  = a.mask ^ b.mask ^ r;
    return q;
  endfunction

  function automatic pair_t conceal(input logic [DW-1:0] raw,
                                    input logic [DW-1:0] r);
    pair_t q;
    q.share = raw ^ r;
    q.mask  = r;
    return q;
  endfunction

  function automatic logic uses_random(input logic [2:0] opc);
    return (opc == OPC_LOAD) || (opc == OPC_XOR) || (opc == OPC_REMASK);
  endfunction

  function automatic logic writes_reg(input logic [2:0] opc);
    return (opc == OPC_LOAD) || (opc == OPC_XOR) ||
           (opc == OPC_MOVE) || (opc == OPC_REMASK);
  endfunction
endpackage

// File: rtl/mdp_prng.sv
`timescale 1ns/1ps
module mdp_prng
  import mdp_pkg::*;
#(
  parameter logic [DW-1:0] TAPS = LFSR_TAPS,
  parameter logic [DW-1:0] SEED = LFSR_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] seed_in,
  input  logic          consume,
  output logic [DW-1:0] rnd
);
  logic [DW-1:0] state_q;
  logic [DW-1:0] reseed_val;

  assign reseed_val = (seed_in == '0) ? SEED : seed_in;
  assign rnd = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= SEED;
    else if (start)   state_q <= reseed_val;
    else if (consume) state_q <= lfsr_step(state_q, TAPS);
  end

  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  assert_lfsr_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !start) |=> state_q != $past(state_q));
  assert_lfsr_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!consume && !start) |=> $stable(state_q));
  assert_seed_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && seed_in != '0) |=> state_q == $past(seed_in));
endmodule

// File: rtl/mdp_rf.sv
`timescale 1ns/1ps
module mdp_rf #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  input  logic [AW-1:0] raddr_c,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  output logic [W-1:0]  rdata_c
);
  logic [W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign ent[i] = '0;
    end else begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                q <= '0;
        else if (we && waddr == AW'(i))            q <= wdata;
      end
      assign ent[i] = q;
    end
  end

  assign rdata_a = ent[raddr_a];
  assign rdata_b = ent[raddr_b];
  assign rdata_c = ent[raddr_c];

  assert_entry0_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr_a == '0) |-> rdata_a == '0);
endmodule

// File: rtl/mdp_alu.sv
`timescale 1ns/1ps
module mdp_alu
  import mdp_pkg::*;
(
  input  logic [2:0]    opc,
  input  pair_t         src_a,
  input  pair_t         src_b,
  input  logic [DW-1:0] raw_in,
  input  logic [DW-1:0] rnd,
  output pair_t         result
);
  always_comb begin
    unique case (opc)
      OPC_LOAD:   result = conceal(raw_in, rnd);
      OPC_XOR:    result = combine(src_a, src_b, rnd);
      OPC_MOVE:   result = src_a;
      OPC_REMASK: result = refresh(src_a, rnd);
      default:    result = '0;
    endcase
  end
endmodule

// File: rtl/masked_regdp.sv
`timescale 1ns/1ps
module masked_regdp
  import mdp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   seed_in,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [AW-1:0] rd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [31:0]   ld_data,
  input  logic [AW-1:0] um_addr,
  output logic [31:0]   um_plain,
  output logic [31:0]   um_share,
  output logic [31:0]   um_mask,
  output logic          st_valid,
  output logic [31:0]   st_share,
  output logic [31:0]   st_mask
);
  // issue decode
  logic [2:0]    issue_op;
  logic          consume;
  logic          wr_req;
  logic [DW-1:0] rnd;

  assign issue_op = op_valid ? op_code : OPC_NOP;
  assign consume  = uses_random(issue_op);
  assign wr_req   = writes_reg(issue_op) && (rd != '0);

  mdp_prng u_prng (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_in(seed_in),
    .consume(consume), .rnd(rnd)
  );

  // execute stage: share and its mask travel together
  logic          ex_we;
  logic [AW-1:0] ex_addr;
  pair_t         ex_pair;

  // parallel share and mask register files
  logic [DW-1:0] sh_a, sh_b, sh_c, mk_a, mk_b, mk_c;

  mdp_rf #(.W(DW), .DEPTH(DEPTH)) u_share_rf (
    .clk(clk), .rst_n(rst_n), .we(ex_we), .waddr(ex_addr), .wdata(ex_pair.share),
    .raddr_a(ra), .raddr_b(rb), .raddr_c(um_addr),
    .rdata_a(sh_a), .rdata_b(sh_b), .rdata_c(sh_c)
  );

  mdp_rf #(.W(DW), .DEPTH(DEPTH)) u_mask_rf (
    .clk(clk), .rst_n(rst_n), .we(ex_we), .waddr(ex_addr), .wdata(ex_pair.mask),
    .raddr_a(ra), .raddr_b(rb), .raddr_c(um_addr),
    .rdata_a(mk_a), .rdata_b(mk_b), .rdata_c(mk_c)
  );

  // bypass from the execute stage
  logic  hit_a, hit_b, hit_c;
  pair_t opnd_a, opnd_b, opnd_c;

  assign hit_a  = ex_we && (ex_addr == ra);
  assign hit_b  = ex_we && (ex_addr == rb);
  assign hit_c  = ex_we && (ex_addr == um_addr);
  assign opnd_a = hit_a ? ex_pair : '{share: sh_a, mask: mk_a};
  assign opnd_b = hit_b ? ex_pair : '{share: sh_b, mask: mk_b};
  assign opnd_c = hit_c ? ex_pair : '{share: sh_c, mask: mk_c};

  pair_t alu_res;

  mdp_alu u_alu (
    .opc(issue_op), .src_a(opnd_a), .src_b(opnd_b),
    .raw_in(ld_data), .rnd(rnd), .result(alu_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_we   <= 1'b0;
      ex_addr <= '0;
      ex_pair <= '0;
    end else begin
      ex_we   <= wr_req;
      ex_addr <= rd;
      ex_pair <= alu_res;
    end
  end

  // unmask (correction) port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      um_plain <= '0;
      um_share <= '0;
      um_mask  <= '0;
    end else begin
      um_plain <= reveal(opnd_c);
      um_share <= opnd_c.share;
      um_mask  <= opnd_c.mask;
    end
  end

  // store transfer port
  logic is_store;
  assign is_store = (issue_op == OPC_STORE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_share <= '0;
      st_mask  <= '0;
    end else begin
      st_valid <= is_store;
      st_share <= is_store ? opnd_a.share : '0;
      st_mask  <= is_store ? opnd_a.mask  : '0;
    end
  end

  // named events for the checks below
  logic xor_issue, remask_issue, move_issue;
  logic [DW-1:0] plain_a, plain_b;
  assign xor_issue    = (issue_op == OPC_XOR);
  assign remask_issue = (issue_op == OPC_REMASK);
  assign move_issue   = (issue_op == OPC_MOVE);
  assign plain_a      = reveal(opnd_a);
  assign plain_b      = reveal(opnd_b);

  assert_no_r0_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ex_we |-> ex_addr != '0);
  assert_r0_unmask_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (um_addr == '0) |=> (um_share == '0 && um_mask == '0));
  assert_xor_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xor_issue && rd != '0) |=> (ex_pair.share ^ ex_pair.mask) == $past(plain_a ^ plain_b));
  assert_remask_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (remask_issue && rd != '0) |=> (ex_pair.share ^ ex_pair.mask) == $past(plain_a));
  assert_move_no_rnd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (move_issue && !start) |=> $stable(rnd));
  assert_store_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> st_valid);
  assert_store_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_store |=> (!st_valid && st_share == '0 && st_mask == '0));
endmodule

// File: tb/sim_masked_regdp.sv
`timescale 1ns/1ps
module sim_masked_regdp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] seed_in = '0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [3:0]  rd = '0, ra = '0, rb = '0, um_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] um_plain, um_share, um_mask, st_share, st_mask;
  logic        st_valid;

  always #4 clk = ~clk; // 125 MHz

  masked_regdp u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_in(seed_in),
    .op_valid(op_valid), .op_code(op_code), .rd(rd), .ra(ra), .rb(rb),
    .ld_data(ld_data), .um_addr(um_addr), .um_plain(um_plain),
    .um_share(um_share), .um_mask(um_mask), .st_valid(st_valid),
    .st_share(st_share), .st_mask(st_mask)
  );

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  // behavioural reference
  logic [31:0] m_sh [16];
  logic [31:0] m_mk [16];
  logic [31:0] m_rng;
  localparam logic [31:0] DEF_SEED = 32'h1D87_2B41;

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] poly;
    logic [31:0] n;
    poly = (32'd1 << 31) | (32'd1 << 21) | (32'd1 << 1) | 32'd1;
    n = {1'b0, s[31:1]};
    return n ^ (poly & {32{s[0]}});
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_sh[i] = '0;
      m_mk[i] = '0;
    end
    m_rng = DEF_SEED;
  endtask

  // one operation plus one unmask read per cycle
  task automatic step(input bit v, input logic [2:0] opc, input logic [3:0] d,
                      input logic [3:0] a, input logic [3:0] b, input logic [31:0] raw,
                      input logic [3:0] u, input bit st, input logic [31:0] sd,
                      input string tag);
    logic [31:0] e_ush, e_umk, e_ssh, e_smk, n_sh, n_mk, r;
    logic e_sv, wr;
    logic [2:0] eff;
    @(negedge clk);
    op_valid = v; op_code = opc; rd = d; ra = a; rb = b; ld_data = raw;
    um_addr = u; start = st; seed_in = sd;
    eff = v ? opc : 3'd0;
    e_ush = m_sh[u]; e_umk = m_mk[u];
    e_sv = (eff == 3'd5);
    e_ssh = e_sv ? m_sh[a] : 32'd0;
    e_smk = e_sv ? m_mk[a] : 32'd0;
    r = m_rng;
    wr = 1'b1; n_sh = '0; n_mk = '0;
    case (eff)
      3'd1: begin n_mk = r; n_sh = raw ^ r; end
      3'd2: begin n_sh = m_sh[a] ^ m_sh[b] ^ r; n_mk = m_mk[a] ^ m_mk[b] ^ r; end
      3'd3: begin n_sh = m_sh[a]; n_mk = m_mk[a]; end
      3'd4: begin n_sh = m_sh[a] ^ r; n_mk = m_mk[a] ^ r; end
      default: wr = 1'b0;
    endcase
    @(posedge clk);
    #1;
    chk({tag, " R1 unmask plain"}, um_plain, e_ush ^ e_umk);
    chk({tag, " R1 unmask share"}, um_share, e_ush);
    chk({tag, " R1 unmask mask"}, um_mask, e_umk);
    if (e_umk != 32'd0) begin
      nvec++;
      if (um_share === um_plain) begin
        nfail++;
        $display("FAIL R1 share equals plain actual=%h expected!=%h", um_share, um_plain);
      end
    end
    chk({tag, " R6 st_valid"}, {31'd0, st_valid}, {31'd0, e_sv});
    chk({tag, " R6 st_share"}, st_share, e_ssh);
    chk({tag, " R6 st_mask"}, st_mask, e_smk);
    if (wr && d != 4'd0) begin
      m_sh[d] = n_sh;
      m_mk[d] = n_mk;
    end
    if (st) m_rng = (sd == 32'd0) ? DEF_SEED : sd;
    else if (eff == 3'd1 || eff == 3'd2 || eff == 3'd4) m_rng = next_rng(m_rng);
  endtask

  task automatic idle_read(input logic [3:0] u, input string tag);
    step(1'b0, 3'd0, 4'd0, 4'd0, 4'd0, 32'd0, u, 1'b0, 32'd0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset um_plain", um_plain, 32'd0);
    chk("R11 reset um_mask", um_mask, 32'd0);
    chk("R11 reset st_valid", {31'd0, st_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 loads, read back later
    step(1, 3'd1, 4'd1, 0, 0, 32'hDEAD_BEEF, 4'd0, 0, 0, "R2 load r1");
    step(1, 3'd1, 4'd2, 0, 0, 32'h0000_0000, 4'd1, 0, 0, "R2 load r2 zero");
    step(1, 3'd1, 4'd3, 0, 0, 32'hFFFF_FFFF, 4'd2, 0, 0, "R2 load r3 ones");
    step(1, 3'd1, 4'd4, 0, 0, 32'h1234_5678, 4'd3, 0, 0, "R2 load r4");
    idle_read(4'd4, "R2 read r4");
    // R9 write to r0 discarded
    step(1, 3'd1, 4'd0, 0, 0, 32'hCAFE_F00D, 4'd0, 0, 0, "R9 load r0");
    idle_read(4'd0, "R9 r0 stays zero");
    // R10 back-to-back dependency and R3 xor
    step(1, 3'd1, 4'd6, 0, 0, 32'h0F0F_0F0F, 4'd0, 0, 0, "R10 load r6");
    step(1, 3'd2, 4'd7, 4'd6, 4'd1, 32'd0, 4'd6, 0, 0, "R10 xor uses bypass");
    step(1, 3'd2, 4'd8, 4'd7, 4'd7, 32'd0, 4'd7, 0, 0, "R3 xor self");
    idle_read(4'd8, "R3 self xor is zero");
    // same-edge write and unmask of one register
    step(1, 3'd1, 4'd2, 0, 0, 32'hA5A5_5A5A, 4'd2, 0, 0, "R1 same edge old value");
    idle_read(4'd2, "R1 new value next edge");
    // R4 move, R5 remask, R6 store
    step(1, 3'd3, 4'd9, 4'd4, 0, 32'd0, 4'd0, 0, 0, "R4 move");
    step(1, 3'd4, 4'd10, 4'd9, 0, 32'd0, 4'd9, 0, 0, "R5 remask");
    step(1, 3'd5, 4'd0, 4'd10, 0, 32'd0, 4'd10, 0, 0, "R6 store r10");
    step(1, 3'd4, 4'd10, 4'd10, 0, 32'd0, 4'd0, 0, 0, "R5 remask in place");
    step(1, 3'd5, 4'd0, 4'd10, 0, 32'd0, 4'd10, 0, 0, "R6 store bypass");
    step(1, 3'd6, 4'd5, 4'd1, 0, 32'h7777_7777, 4'd5, 0, 0, "R6 code 6 no effect");
    step(0, 3'd1, 4'd5, 4'd1, 0, 32'h7777_7777, 4'd5, 0, 0, "R6 invalid no effect");
    idle_read(4'd5, "R6 r5 untouched");
    // R8 reseed, including with a concurrent load, and zero seed
    step(1, 3'd1, 4'd11, 0, 0, 32'h0BAD_CAFE, 4'd0, 1, 32'h0000_1001, "R8 start with load");
    step(1, 3'd1, 4'd12, 0, 0, 32'h1111_2222, 4'd11, 0, 0, "R8 first after seed");
    step(1, 3'd1, 4'd13, 0, 0, 32'h3333_4444, 4'd12, 1, 32'd0, "R8 zero seed");
    step(1, 3'd1, 4'd14, 0, 0, 32'h5555_6666, 4'd13, 0, 0, "R7 after default");
    idle_read(4'd14, "R7 read r14");

    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)), 4'($urandom),
           4'($urandom), 4'($urandom), $urandom, 4'($urandom),
           $urandom_range(0, 40) == 0, ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom,
           "R7 mixed");
    end
    for (int i = 0; i < 16; i++) idle_read(4'(i), "R1 final sweep");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule